// File: doc/BRIEF.md
# Multi-mode link test pattern generator

This block produces link quality test patterns for a high-speed serial transmitter. Every clock it delivers one 32-bit word in the selected mode. The modes are six pseudo-random binary sequences, a 264-bit pattern supplied by the user that repeats, a square wave with a programmable run length, and an alternating-bit training pattern at the Nyquist rate. Bit 0 of each output word is the first bit on the line.

The mode and the square-wave run length are chosen at run time. A pattern starts again from its defined starting point whenever the enable rises, the mode code changes, or the half-period code changes. While the enable is low the output is zero and the valid flag is low. The 264-bit custom pattern is not a whole multiple of the word width, so the custom mode keeps a bit pointer that wraps modulo 264. A single word can therefore cross the end of the pattern.

Top module: `lqpat_gen`

## Requirements
- R1: When `en` was high at a rising edge and `mode` held a supported code (0 to 8), `dout_vld` is high after that edge and `dout` holds the word for those inputs, so the latency is one cycle.
- R2: The mode codes 0, 1, 2, 3, 4 and 5 select the sequences of order 7, 9, 11, 15, 23 and 31. Their polynomials are x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. The generator is a Fibonacci register of order N with taps at N and T. Each step computes fb = s[N-1]^s[T-1], shifts the register left with fb entering bit 0, and emits fb. Each word carries 32 steps, with the first step in bit 0.
- R3: The shift register is seeded to all ones on every restart (enable rising, or a change of mode or half-period code). A sequence word is never all zeros.
- R4: Mode code 6 outputs bit i of the word as pattern bit (p+i) mod 264. The pointer p starts at 0 on a restart and advances by 32 each word, so the output repeats every 33 words.
- R5: Mode code 7 with half-period code h (6 bits) outputs runs of h+1 ones followed by h+1 zeros, starting with ones. This gives run lengths of 1 to 64 bits.
- R6: The square-wave phase carries across word boundaries without a gap. With h = 31, consecutive words are bitwise complements.
- R7: Mode code 8 outputs the alternating pattern 0x55555555 on every word.
- R8: After a rising edge where `en` is low, `dout` is zero and `dout_vld` is low.
- R9: Mode codes 9 to 15 are unsupported: `dout` is zero and `dout_vld` is low.
- R10: A change of mode code while enabled restarts the newly selected pattern from its starting point on the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generation enable |
| mode | input | 4 | Pattern select code (0-5 sequences, 6 custom, 7 square, 8 training) |
| sq_half | input | 6 | Square-wave run length minus one |
| cust_pat | input | 264 | User pattern, bit 0 sent first |
| dout | output | 32 | Pattern word, bit 0 first on the line |
| dout_vld | output | 1 | Word valid |

## Verification
The bench runs the order-7 sequence past its 127-bit period, so a wrong tap or bit order produces a mismatched word almost immediately. It runs the custom pattern for more than 33 words, so a pointer that wraps at a word boundary instead of at bit 264 corrupts the words that cross the pattern end. It sets square-wave run lengths of 1, 5, 32 and 64 bits: a phase counter that resets at each word, or an off-by-one run length, shifts the edges. It also switches mode directly, drops and raises the enable, and selects an unsupported code, so that a missing reseed or a stray valid flag appears as a mismatch or as an unexpected word.

// File: rtl/lqpat_gen.sv
module lqpat_gen (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   mode,
  input  logic [5:0]   sq_half,
  input  logic [263:0] cust_pat,
  output logic [31:0]  dout,
  output logic         dout_vld
);
  localparam int W = 32;
  localparam int PLEN = 264;

  logic         en_q;
  logic [3:0]   mode_q;
  logic [5:0]   half_q;
  logic [30:0]  lfsr;
  logic [8:0]   ptr;
  logic [7:0]   sqpos;

  logic         restart;
  logic [30:0]  lfsr_src, lfsr_nx;
  logic [8:0]   ptr_src, ptr_nx;
  logic [7:0]   sq_src, sq_nx;
  logic [W-1:0] prbs_w, cust_w, sq_w;
  logic [PLEN+W-1:0] dbl;

  assign restart  = !en_q || (mode != mode_q) || (sq_half != half_q);
  assign lfsr_src = restart ? '1 : lfsr;
  assign ptr_src  = restart ? '0 : ptr;
  assign sq_src   = restart ? '0 : sqpos;

  always_comb begin
    logic [30:0] s;
    logic [4:0]  n, t;
    logic        fb;
    case (mode)
      4'd0:    begin n = 5'd7;  t = 5'd6;  end
      4'd1:    begin n = 5'd9;  t = 5'd5;  end
      4'd2:    begin n = 5'd11; t = 5'd9;  end
      4'd3:    begin n = 5'd15; t = 5'd14; end
      4'd4:    begin n = 5'd23; t = 5'd18; end
      default: begin n = 5'd31; t = 5'd28; end
    endcase
    s = lfsr_src;
    prbs_w = '0;
    for (int i = 0; i < W; i++) begin
      fb = s[n - 5'd1] ^ s[t - 5'd1];
      s = {s[29:0], fb};
      prbs_w[i] = fb;
    end
    lfsr_nx = s;
  end

  assign dbl    = {cust_pat[W-1:0], cust_pat};
  assign cust_w = dbl[ptr_src +: W];
  assign ptr_nx = (ptr_src + 9'd32 >= 9'(PLEN)) ? ptr_src + 9'd32 - 9'(PLEN) : ptr_src + 9'd32;

  always_comb begin
    logic [7:0] h, p, pos;
    h = 8'(sq_half) + 8'd1;
    p = h << 1;
    pos = sq_src;
    sq_w = '0;
    for (int i = 0; i < W; i++) begin
      sq_w[i] = (pos < h);
      pos = (pos + 8'd1 == p) ? 8'd0 : pos + 8'd1;
    end
    sq_nx = pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mode_q   <= '0;
      half_q   <= '0;
      lfsr     <= '1;
      ptr      <= '0;
      sqpos    <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      en_q   <= en;
      mode_q <= mode;
      half_q <= sq_half;
      if (!en) begin
        dout     <= '0;
        dout_vld <= 1'b0;
      end else begin
        dout_vld <= 1'b1;
        case (mode)
          4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
            dout <= prbs_w;
            lfsr <= lfsr_nx;
          end
          4'd6: begin
            dout <= cust_w;
            ptr  <= ptr_nx;
          end
          4'd7: begin
            dout  <= sq_w;
            sqpos <= sq_nx;
          end
          4'd8: dout <= 32'h5555_5555;
          default: begin
            dout     <= '0;
            dout_vld <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

module lqpat_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [3:0]   mode,
  input logic [5:0]   sq_half,
  input logic [31:0]  dout,
  input logic         dout_vld
);
  AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode <= 4'd8) |=> dout_vld); // R1
  AST_PRBS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode <= 4'd5) |=> (dout != 32'd0)); // R3
  AST_SQ_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 4'd7 && sq_half == 6'd31 && $past(en && mode == 4'd7 && sq_half == 6'd31))
    |=> (dout == ~$past(dout))); // R6
  AST_TRAIN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 4'd8) |=> (dout == 32'h5555_5555)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dout == 32'd0 && !dout_vld)); // R8
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode > 4'd8) |=> (!dout_vld && dout == 32'd0)); // R9
endmodule

bind lqpat_gen lqpat_gen_chk u_chk (.*);

// File: tb/lqpat_gen_test.sv
`timescale 1ns/1ps
module lqpat_gen_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [3:0]   mode = '0;
  logic [5:0]   sq_half = '0;
  logic [263:0] cust_pat = '0;
  logic [31:0]  dout;
  logic         dout_vld;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  lqpat_gen uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [5:0] h, input int n, input string req);
    logic [30:0] s;
    logic [31:0] w;
    int p, sp, hn, tn, tt;
    logic fb;
    s = '1; p = 0; sp = 0;
    case (m)
      4'd0: begin tn = 7;  tt = 6;  end
      4'd1: begin tn = 9;  tt = 5;  end
      4'd2: begin tn = 11; tt = 9;  end
      4'd3: begin tn = 15; tt = 14; end
      4'd4: begin tn = 23; tt = 18; end
      default: begin tn = 31; tt = 28; end
    endcase
    hn = int'(h) + 1;
    @(negedge clk);
    en = 1'b1; mode = m; sq_half = h;
    if (m <= 4'd8) begin
      for (int k = 0; k < n; k++) begin
        w = '0;
        for (int i = 0; i < 32; i++) begin
          if (m <= 4'd5) begin
            fb = s[tn-1] ^ s[tt-1];
            s = {s[29:0], fb};
            w[i] = fb;
          end else if (m == 4'd6) begin
            w[i] = cust_pat[p];
            p = (p + 1) % 264;
          end else if (m == 4'd7) begin
            w[i] = (sp < hn);
            sp = (sp + 1) % (2 * hn);
          end else begin
            w[i] = (i % 2 == 0);
          end
        end
        exp_q.push_back(w);
        tag_q.push_back(req);
      end
    end
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (dout_vld) begin
        if (exp_q.size() == 0) chk(1'b0, "R9/R8 unexpected valid", dout, 32'd0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(dout == e, t, dout, e);
        end
      end else begin
        chk(dout == 32'd0, "R8/R9 idle word", dout, 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 264; i++)
      cust_pat[i] = (((i * 7 + 3) % 11) < 5) ^ (i % 3 == 0) ^ (i > 250);
    repeat (3) @(negedge clk);
    chk(dout == 32'd0 && !dout_vld, "R8 reset state", {31'd0, dout_vld} | dout, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    idle(3);
    run(4'd0, 6'd0, 130, "R2 order7");
    run(4'd1, 6'd0, 10, "R10 switch to order9");
    run(4'd2, 6'd0, 8, "R2 order11");
    run(4'd3, 6'd0, 8, "R2 order15");
    run(4'd4, 6'd0, 8, "R2 order23");
    run(4'd5, 6'd0, 8, "R2 order31");
    idle(2);
    run(4'd5, 6'd0, 4, "R3 reseed on enable");
    run(4'd6, 6'd0, 40, "R4 custom wrap");
    run(4'd7, 6'd0, 4, "R5 square run 1");
    run(4'd7, 6'd4, 10, "R5 square run 5");
    run(4'd7, 6'd63, 6, "R5 square run 64");
    run(4'd7, 6'd31, 6, "R6 square run 32");
    run(4'd8, 6'd0, 4, "R7 training");
    run(4'd12, 6'd0, 3, "R9 bad mode");
    run(4'd0, 6'd0, 5, "R1 restart after bad mode");
    idle(4);
    @(negedge clk);
    chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule